// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address stream for a single SDRAM read or write burst. A controller raises a start strobe together with the starting column, the programmed burst length code, the ordering (sequential or interleaved), the direction of the access and the single-location-write mode bit. The sequencer then puts out one column address per clock, with a valid flag, until the burst is over. It also raises a last flag on the final address of a burst that has a fixed length.

In sequential order, the low address bits count upward inside the block of columns aligned to the burst length. In interleaved order, the low bits are the start column XOR the beat index. The bits above the burst-length boundary never change within a burst. A full-page burst walks every column of the row in sequential order and wraps at the row end. It runs until a burst stop or a new start arrives. A start can be accepted on any clock, so a new burst can cut into the one in progress. Data capture, masking and bank timing are handled elsewhere.

Top module: `col_burst_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `col_o` is 0 and `valid_o` and `last_o` are low.
- R2: In sequential order, beat i carries the low bits (start + i) mod L for a burst of length L. For example, start 1 with length 4 gives 1,2,3,0.
- R3: In interleaved order, beat i carries the start column XOR i. For example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R4: The column bits at and above bit log2(L) keep the start column's value for the whole burst.
- R5: The length code `blen_i` is sampled with the start. Code 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. Codes 4, 5 and 6 give a single beat.
- R6: A full-page burst uses sequential order whatever `interleave_i` says. It steps through all 2^COL_W columns, wraps from the top column to 0 and continues without end. `last_o` never rises during a full-page burst.
- R7: `last_o` is high on the final beat of a fixed-length burst, and only there. `valid_o` is low on the next cycle unless a new start was given. A one-beat burst has `last_o` high on its only beat.
- R8: A `stop_i` sampled without `start_i` ends the burst: `valid_o` and `last_o` are low from the next cycle. This applies at any length.
- R9: A `start_i` sampled at a rising edge presents its start column with `valid_o` high in the next cycle. This holds even in the middle of a burst, and a start takes priority over a stop in the same cycle.
- R10: When `single_wr_i` is set, a write burst (`is_write_i` = 1) lasts one beat with `last_o` high. A read burst still uses the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new burst this cycle |
| start_col_i | input | COL_W | Starting column of the burst |
| blen_i | input | 3 | Burst length code (see R5) |
| interleave_i | input | 1 | 1 selects interleaved order, 0 sequential |
| is_write_i | input | 1 | 1 marks the burst as a write |
| single_wr_i | input | 1 | Single-location-write mode |
| stop_i | input | 1 | Burst stop |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | `col_o` carries a beat |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
Several properties are checked on every cycle. A start shows its column on the next cycle, and a stop ends the output. Nothing is valid after a last beat. The upper bits stay fixed inside a burst. Each sequential step advances the low bits by one modulo the burst length, each interleaved beat equals the start XOR the beat count, and a full-page burst never flags a last beat.

Only the bench scenarios can show the following:
- the exact address lists for given starts;
- the beat count for each length code, including the reserved codes;
- the wrap at the row end after 512 beats;
- that single-location-write mode shortens writes but leaves reads alone.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [2:0] {
    BLEN_1    = 3'd0,
    BLEN_2    = 3'd1,
    BLEN_4    = 3'd2,
    BLEN_8    = 3'd3,
    BLEN_PAGE = 3'd7
  } blen_e;

endpackage

// File: rtl/cbs_len_decode.sv
module cbs_len_decode
  import cbs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code_i,
  input  logic             il_req_i,
  input  logic             is_write_i,
  input  logic             single_wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o,
  output logic             il_o
);

  logic [COL_W-1:0] code_mask;
  logic             code_page;

  always_comb begin
    code_page = 1'b0;
    code_mask = '0;
    case (code_i)
      BLEN_2:    code_mask = COL_W'(1);
      BLEN_4:    code_mask = COL_W'(3);
      BLEN_8:    code_mask = COL_W'(7);
      BLEN_PAGE: begin
        code_mask = '1;
        code_page = 1'b1;
      end
      default:   code_mask = '0;
    endcase
  end

  // A write in single-location mode is always one beat long.
  always_comb begin
    if (single_wr_i && is_write_i) begin
      mask_o = '0;
      page_o = 1'b0;
    end else begin
      mask_o = code_mask;
      page_o = code_page;
    end
    il_o = il_req_i && !page_o;
  end

endmodule

// File: rtl/cbs_addr_calc.sv
module cbs_addr_calc #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] low;

  assign sum = base_i + beat_i;

  always_comb begin
    if (il_i) low = base_i ^ beat_i;
    else      low = sum;
    col_o = (base_i & ~mask_i) | (low & mask_i);
  end

endmodule

// File: rtl/col_burst_seq.sv
module col_burst_seq
  import cbs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             interleave_i,
  input  logic             is_write_i,
  input  logic             single_wr_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic [COL_W-1:0] mask_d;
  logic             page_d;
  logic             il_d;

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] beat_q;
  logic             il_q;
  logic             page_q;

  logic [COL_W-1:0] beat_nxt;
  logic [COL_W-1:0] col_nxt;

  cbs_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i      (blen_i),
    .il_req_i    (interleave_i),
    .is_write_i  (is_write_i),
    .single_wr_i (single_wr_i),
    .mask_o      (mask_d),
    .page_o      (page_d),
    .il_o        (il_d)
  );

  assign beat_nxt = beat_q + COL_W'(1);

  cbs_addr_calc #(.COL_W(COL_W)) u_calc (
    .base_i (base_q),
    .beat_i (beat_nxt),
    .mask_i (mask_q),
    .il_i   (il_q),
    .col_o  (col_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      mask_q  <= '0;
      beat_q  <= '0;
      il_q    <= 1'b0;
      page_q  <= 1'b0;
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (start_i) begin
      base_q  <= start_col_i;
      mask_q  <= mask_d;
      beat_q  <= '0;
      il_q    <= il_d;
      page_q  <= page_d;
      col_o   <= start_col_i;
      valid_o <= 1'b1;
      last_o  <= !page_d && (mask_d == '0);
    end else if (stop_i) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (valid_o && !last_o) begin
      beat_q  <= beat_nxt;
      col_o   <= col_nxt;
      last_o  <= !page_q && (beat_nxt == mask_q);
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end
  end

  AST_START_SHOWS_COL: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(start_col_i))); // R9

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !start_i) |=> !valid_o); // R8

  AST_NOTHING_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o); // R7

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o); // R7

  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (rst)
    (valid_o && page_q) |-> !last_o); // R6

  AST_HIGH_BITS_FIXED: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(valid_o) && !$past(start_i))
      |-> (((col_o ^ $past(col_o)) & ~mask_q) == '0)); // R4

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(valid_o) && !$past(start_i) && !il_q)
      |-> (((col_o - $past(col_o)) & mask_q) == COL_W'(1))); // R2

  AST_IL_XOR: assert property (@(posedge clk) disable iff (rst)
    (valid_o && il_q) |-> (((col_o ^ base_q) & mask_q) == beat_q)); // R3

endmodule

// File: tb/tb_col_burst_seq.sv
module tb_col_burst_seq;

  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       blen_i = '0;
  logic             interleave_i = 1'b0;
  logic             is_write_i = 1'b0;
  logic             single_wr_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  col_burst_seq #(.COL_W(COL_W)) dut (
    .clk, .rst, .start_i, .start_col_i, .blen_i, .interleave_i,
    .is_write_i, .single_wr_i, .stop_i, .col_o, .valid_o, .last_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(input int s, input int len, input bit il, input int i);
    int off = s % len;
    int base = s - off;
    if (il) return s ^ i;
    return base + ((off + i) % len);
  endfunction

  task automatic launch(input int col, input int code, input bit il,
                        input bit wr, input bit swr);
    start_i      = 1'b1;
    start_col_i  = COL_W'(col);
    blen_i       = 3'(code);
    interleave_i = il;
    is_write_i   = wr;
    single_wr_i  = swr;
  endtask

  // Beat i is on the outputs at the i-th falling edge after launch.
  task automatic expect_beat(input int exp, input bit exp_last, input string req);
    @(negedge clk);
    start_i = 1'b0;
    check(valid_o === 1'b1, req, int'(valid_o), 1);
    check(int'(col_o) == exp, req, int'(col_o), exp);
    check(last_o === exp_last, req, int'(last_o), int'(exp_last));
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    start_i = 1'b0;
    stop_i  = 1'b0;
    check(valid_o === 1'b0, req, int'(valid_o), 0);
    check(last_o === 1'b0, req, int'(last_o), 0);
  endtask

  task automatic run_fixed(input int col, input int code, input bit il,
                           input bit wr, input bit swr, input int len, input string req);
    @(negedge clk);
    launch(col, code, il, wr, swr);
    for (int i = 0; i < len; i++)
      expect_beat(exp_col(col, len, il, i), i == len - 1, req);
    expect_idle(req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0 && last_o === 1'b0 && col_o == '0, "R1 reset", int'(valid_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(valid_o === 1'b0 && col_o == '0, "R1 after reset", int'(col_o), 0);
  endtask

  task automatic t_sequential;
    run_fixed(1, 2, 1'b0, 1'b0, 1'b0, 4, "R2 seq start1 len4");
    run_fixed(9'h103, 2, 1'b0, 1'b0, 1'b0, 4, "R4 seq high bits len4");
    run_fixed(9'h0F3, 1, 1'b0, 1'b0, 1'b0, 2, "R5 seq len2");
    run_fixed(9'h1EE, 3, 1'b0, 1'b0, 1'b0, 8, "R4 seq len8 high bits");
  endtask

  task automatic t_interleave;
    run_fixed(5, 3, 1'b1, 1'b0, 1'b0, 8, "R3 il start5 len8");
    run_fixed(9'h0AD, 3, 1'b1, 1'b1, 1'b0, 8, "R4 il high bits len8");
    run_fixed(9'h056, 2, 1'b1, 1'b0, 1'b0, 4, "R3 il len4");
  endtask

  task automatic t_lengths;
    run_fixed(9'h123, 0, 1'b0, 1'b0, 1'b0, 1, "R7 len1 last");
    run_fixed(9'h077, 4, 1'b0, 1'b0, 1'b0, 1, "R5 reserved code4");
    run_fixed(9'h046, 6, 1'b1, 1'b0, 1'b0, 1, "R5 reserved code6");
  endtask

  task automatic t_page(input bit il);
    int s = 9'h1FE;
    @(negedge clk);
    launch(s, 7, il, 1'b0, 1'b0);
    for (int i = 0; i < PAGE + 20; i++)
      expect_beat((s + i) % PAGE, 1'b0, "R6 full page");
    stop_i = 1'b1;
    expect_idle("R8 stop full page");
  endtask

  task automatic t_stop;
    @(negedge clk);
    launch(9'h0C2, 3, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++)
      expect_beat(exp_col(9'h0C2, 8, 1'b1, i), 1'b0, "R8 pre-stop");
    stop_i = 1'b1;
    expect_idle("R8 stop len8");
    expect_idle("R8 stays idle");
  endtask

  task automatic t_restart;
    @(negedge clk);
    launch(9'h010, 3, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++)
      expect_beat(exp_col(9'h010, 8, 1'b0, i), 1'b0, "R9 first burst");
    launch(9'h15D, 2, 1'b1, 1'b0, 1'b0);
    stop_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      expect_beat(exp_col(9'h15D, 4, 1'b1, i), i == 3, "R9 restart wins over stop");
      stop_i = 1'b0;
    end
    expect_idle("R9 restart end");
  endtask

  task automatic t_single_write;
    run_fixed(9'h035, 3, 1'b0, 1'b1, 1'b1, 1, "R10 single write");
    run_fixed(9'h035, 3, 1'b0, 1'b0, 1'b1, 8, "R10 read keeps length");
    run_fixed(9'h0E1, 7, 1'b0, 1'b1, 1'b1, 1, "R10 single write page code");
    run_fixed(9'h035, 2, 1'b1, 1'b1, 1'b0, 4, "R10 write mode off");
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_interleave();
    t_lengths();
    t_page(1'b0);
    t_page(1'b1);
    t_stop();
    t_restart();
    t_single_write();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule